// File: doc/BRIEF.md
# Single-Cycle 32-bit Seven-Instruction Processor Core

This block is a 32-bit processor core that fetches, decodes, executes and retires one instruction in every clock cycle. It recognises seven instructions: register add and subtract, OR with an immediate, load word, store word, branch-if-equal and an absolute jump. The core holds the program counter, a 32-entry by 32-bit register file, an add/subtract/OR arithmetic unit that also flags a zero result, an immediate widener and the next-address logic.

Both memories sit outside the core. The instruction side is a plain address out and a word back in the same cycle. The data side drives an address, write data and a write strobe, and returns read data in the same cycle. Register and memory writes take effect on the rising clock edge. Every read is combinational. The data address port always carries the arithmetic result and the write-data port always carries the register named by the rt field, so the datapath can be seen at the pins on every instruction.

Top module: `onecycle_cpu`

## Requirements
- R1: A synchronous active-high reset loads the program counter with 0 and clears every register to zero. `imem_addr` shows the program counter at all times.
- R2: Any instruction that is not a branch or a jump moves the program counter to PC+4 at the next rising edge.
- R3: With opcode bits [31:26] = 000000, funct bits [5:0] = 100000 writes R[rs]+R[rt] and funct 100010 writes R[rs]−R[rt] into rd. The fields are rs = [25:21], rt = [20:16] and rd = [15:11]. Both wrap modulo 2^32 with no overflow trap.
- R4: Opcode 001101 writes R[rs] OR the zero-extended imm16 (bits [15:0]) into rt.
- R5: Opcode 100011 puts R[rs] + sign-extended imm16 on `dmem_addr` and writes `dmem_rdata` into rt at the edge.
- R6: Opcode 101011 raises `dmem_we` and drives `dmem_addr` = R[rs] + sign-extended imm16 and `dmem_wdata` = R[rt]. It writes no register.
- R7: Opcode 000100 subtracts R[rt] from R[rs]. If the result is zero, the next PC is PC+4+(sign-extended imm16 << 2). Otherwise it is PC+4. No register or memory write takes place.
- R8: Opcode 000010 sets the next PC to {PC[31:28], target[25:0], 00}, where target is instruction bits [25:0].
- R9: Register 0 always reads as zero, and writes aimed at it are dropped.
- R10: An unlisted opcode, or an R-type funct other than the two in R3, writes no register and no memory and advances to PC+4.
- R11: For a jump and for unlisted codes, the arithmetic unit adds R[rs] and R[rt] taken from bits [25:21] and [20:16]. `dmem_addr` always shows the arithmetic result and `dmem_wdata` always shows R[rt].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Fetch address (current PC) |
| imem_data | input | 32 | Instruction word at `imem_addr` |
| dmem_addr | output | 32 | Data address (arithmetic result) |
| dmem_wdata | output | 32 | Store data, register rt |
| dmem_we | output | 1 | Data write strobe |
| dmem_rdata | input | 32 | Data word at `dmem_addr` |

## Verification
The bench builds the core with its defaults: a reset address of 0 and the fixed 32-register file. Under these values a short program placed at low addresses reaches every decode path. This includes forward and backward branches, a jump into a second code region, and loads and stores whose sign-extended negative offset lands in the top word of a 64-word data model. Because the program stays below 256 bytes, the upper four PC bits kept by a jump are always zero. The concatenation itself is therefore checked by a clocked property that compares against the previous PC, rather than by a vector.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned OP_W    = 6;
  localparam int unsigned RIDX_W  = 5;
  localparam int unsigned IMM_W   = 16;
  localparam int unsigned TGT_W   = 26;
  localparam int unsigned NUM_REGS = 1 << RIDX_W;
  localparam int unsigned KEEP_W  = WORD_W - TGT_W - 2;
  localparam logic [WORD_W-1:0] PC_STEP = WORD_W'(4);

  localparam logic [OP_W-1:0] OP_RTYPE = 6'b000000;
  localparam logic [OP_W-1:0] OP_ORI   = 6'b001101;
  localparam logic [OP_W-1:0] OP_LW    = 6'b100011;
  localparam logic [OP_W-1:0] OP_SW    = 6'b101011;
  localparam logic [OP_W-1:0] OP_BEQ   = 6'b000100;
  localparam logic [OP_W-1:0] OP_J     = 6'b000010;
  localparam logic [5:0]      FN_ADD   = 6'b100000;
  localparam logic [5:0]      FN_SUB   = 6'b100010;

  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_OR} alu_op_e;

  typedef struct packed {
    logic    reg_wr;
    logic    dst_rd;
    logic    use_imm;
    logic    imm_signed;
    logic    mem_wr;
    logic    mem_to_reg;
    logic    is_branch;
    logic    is_jump;
    alu_op_e alu_op;
  } ctrl_t;

  function automatic logic [WORD_W-1:0] alu_eval(alu_op_e op, logic [WORD_W-1:0] a,
                                                 logic [WORD_W-1:0] b);
    case (op)
      ALU_SUB: return a - b;
      ALU_OR:  return a | b;
      default: return a + b;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] widen_imm(logic [IMM_W-1:0] imm, logic sgn);
    if (sgn) return {{(WORD_W-IMM_W){imm[IMM_W-1]}}, imm};
    return {{(WORD_W-IMM_W){1'b0}}, imm};
  endfunction

  function automatic logic [WORD_W-1:0] branch_dest(logic [WORD_W-1:0] seq_pc,
                                                    logic [IMM_W-1:0] imm);
    return seq_pc + (widen_imm(imm, 1'b1) << 2);
  endfunction

  function automatic logic [WORD_W-1:0] jump_dest(logic [WORD_W-1:0] pc,
                                                  logic [TGT_W-1:0] tgt);
    return {pc[WORD_W-1 -: KEEP_W], tgt, 2'b00};
  endfunction
endpackage

// File: rtl/ocp_decode.sv
module ocp_decode
  import ocp_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  input  logic [5:0]      funct,
  output ctrl_t           ctrl
);
  always_comb begin
    ctrl        = '0;
    ctrl.alu_op = ALU_ADD;
    case (opcode)
      OP_RTYPE: begin
        case (funct)
          FN_ADD: begin
            ctrl.reg_wr = 1'b1;
            ctrl.dst_rd = 1'b1;
          end
          FN_SUB: begin
            ctrl.reg_wr = 1'b1;
            ctrl.dst_rd = 1'b1;
            ctrl.alu_op = ALU_SUB;
          end
          default: ;
        endcase
      end
      OP_ORI: begin
        ctrl.reg_wr  = 1'b1;
        ctrl.use_imm = 1'b1;
        ctrl.alu_op  = ALU_OR;
      end
      OP_LW: begin
        ctrl.reg_wr     = 1'b1;
        ctrl.use_imm    = 1'b1;
        ctrl.imm_signed = 1'b1;
        ctrl.mem_to_reg = 1'b1;
      end
      OP_SW: begin
        ctrl.mem_wr     = 1'b1;
        ctrl.use_imm    = 1'b1;
        ctrl.imm_signed = 1'b1;
      end
      OP_BEQ: begin
        ctrl.is_branch = 1'b1;
        ctrl.alu_op    = ALU_SUB;
      end
      OP_J: ctrl.is_jump = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/ocp_regfile.sv
module ocp_regfile
  import ocp_pkg::*;
#(
  parameter int unsigned DEPTH = NUM_REGS,
  parameter int unsigned DW    = WORD_W,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] ra,
  input  logic [IDX_W-1:0] rb,
  input  logic [IDX_W-1:0] wa,
  input  logic             we,
  input  logic [DW-1:0]    wd,
  output logic [DW-1:0]    rda,
  output logic [DW-1:0]    rdb
);
  logic [DW-1:0] regs [DEPTH];

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (rst || i == 0) regs[i] <= '0;
      else if (we && wa == IDX_W'(i)) regs[i] <= wd;
    end
  end

  assign rda = regs[ra];
  assign rdb = regs[rb];

  // R9
  r0_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rb == '0) |-> (rdb == '0));

  // R3
  wb_visible_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(we) && $past(wa) != '0 && ra == $past(wa)) |-> (rda == $past(wd)));
endmodule

// File: rtl/ocp_alu.sv
module ocp_alu
  import ocp_pkg::*;
(
  input  alu_op_e           op,
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  output logic [WORD_W-1:0] res,
  output logic              zero
);
  assign res  = alu_eval(op, a, b);
  assign zero = (res == '0);
endmodule

// File: rtl/ocp_nextpc.sv
module ocp_nextpc
  import ocp_pkg::*;
(
  input  logic [WORD_W-1:0] pc,
  input  logic [IMM_W-1:0]  imm,
  input  logic [TGT_W-1:0]  tgt,
  input  logic              is_branch,
  input  logic              is_jump,
  input  logic              zero,
  output logic              br_taken,
  output logic [WORD_W-1:0] npc
);
  logic [WORD_W-1:0] seq_pc;

  assign seq_pc   = pc + PC_STEP;
  assign br_taken = is_branch & zero;

  always_comb begin
    if (is_jump)       npc = jump_dest(pc, tgt);
    else if (br_taken) npc = branch_dest(seq_pc, imm);
    else               npc = seq_pc;
  end
endmodule

// File: rtl/onecycle_cpu.sv
module onecycle_cpu
  import ocp_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_data,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  output logic        dmem_we,
  input  logic [31:0] dmem_rdata
);
  logic [WORD_W-1:0] pc_q, npc;
  logic [OP_W-1:0]   f_op;
  logic [RIDX_W-1:0] f_rs, f_rt, f_rd, wr_idx;
  logic [5:0]        f_fn;
  logic [IMM_W-1:0]  f_imm;
  logic [TGT_W-1:0]  f_tgt;
  ctrl_t             ctrl;
  logic [WORD_W-1:0] rs_val, rt_val, imm_ext, alu_b, alu_res, wb_data;
  logic              alu_zero, br_taken, rf_we;
  logic              is_ori, known_code;

  assign f_op  = imem_data[31:26];
  assign f_rs  = imem_data[25:21];
  assign f_rt  = imem_data[20:16];
  assign f_rd  = imem_data[15:11];
  assign f_fn  = imem_data[5:0];
  assign f_imm = imem_data[IMM_W-1:0];
  assign f_tgt = imem_data[TGT_W-1:0];

  ocp_decode u_dec (.opcode(f_op), .funct(f_fn), .ctrl(ctrl));

  assign wr_idx = ctrl.dst_rd ? f_rd : f_rt;
  assign rf_we  = ctrl.reg_wr;

  ocp_regfile #(.DEPTH(NUM_REGS), .DW(WORD_W)) u_rf (
    .clk(clk), .rst(rst), .ra(f_rs), .rb(f_rt), .wa(wr_idx),
    .we(rf_we), .wd(wb_data), .rda(rs_val), .rdb(rt_val)
  );

  assign imm_ext = widen_imm(f_imm, ctrl.imm_signed);
  assign alu_b   = ctrl.use_imm ? imm_ext : rt_val;

  ocp_alu u_alu (.op(ctrl.alu_op), .a(rs_val), .b(alu_b), .res(alu_res), .zero(alu_zero));

  assign wb_data = ctrl.mem_to_reg ? dmem_rdata : alu_res;

  ocp_nextpc u_npc (
    .pc(pc_q), .imm(f_imm), .tgt(f_tgt), .is_branch(ctrl.is_branch),
    .is_jump(ctrl.is_jump), .zero(alu_zero), .br_taken(br_taken), .npc(npc)
  );

  always_ff @(posedge clk) begin
    if (rst) pc_q <= RESET_PC;
    else     pc_q <= npc;
  end

  assign imem_addr  = pc_q;
  assign dmem_addr  = alu_res;
  assign dmem_wdata = rt_val;
  assign dmem_we    = ctrl.mem_wr;

  // Independent views of the instruction word for the checks below.
  assign is_ori     = (f_op == OP_ORI);
  assign known_code = (f_op == OP_ORI) || (f_op == OP_LW) || (f_op == OP_SW) ||
                      (f_op == OP_BEQ) || (f_op == OP_J) ||
                      ((f_op == OP_RTYPE) && (f_fn == FN_ADD || f_fn == FN_SUB));

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.is_branch && !ctrl.is_jump) |=> (imem_addr == $past(imem_addr) + 32'd4));

  // R7
  br_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl.is_branch && rs_val == rt_val) |=>
      (imem_addr == $past(imem_addr) + 32'd4 +
        {{14{$past(imem_data[15])}}, $past(imem_data[15:0]), 2'b00}));

  // R7
  br_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl.is_branch && rs_val != rt_val) |=> (imem_addr == $past(imem_addr) + 32'd4));

  // R8
  jump_dest_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl.is_jump |=>
      (imem_addr == {$past(imem_addr[31:28]), $past(imem_data[25:0]), 2'b00}));

  // R6
  store_no_wb_chk: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> !rf_we);

  // R4
  ori_zext_chk: assert property (@(posedge clk) disable iff (rst)
    is_ori |-> (wb_data[31:16] == rs_val[31:16]));

  // R10
  unknown_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !known_code |-> (!rf_we && !dmem_we && !br_taken && !ctrl.is_jump));
endmodule

// File: tb/test_onecycle_cpu.sv
module test_onecycle_cpu;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;
  logic [31:0] dmem_model [64];
  int          checks = 0;
  int          fails  = 0;
  bit          done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  onecycle_cpu i_onecycle_cpu (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_rdata(dmem_rdata)
  );

  assign dmem_rdata = dmem_model[dmem_addr[7:2]];
  always @(posedge clk) if (dmem_we) dmem_model[dmem_addr[7:2]] <= dmem_wdata;

  function automatic logic [31:0] enc_r(logic [4:0] rs, logic [4:0] rt, logic [4:0] rd,
                                        logic [5:0] fn);
    return {6'b000000, rs, rt, rd, 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs, logic [4:0] rt,
                                        logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction
  function automatic logic [31:0] enc_j(logic [25:0] tgt);
    return {6'b000010, tgt};
  endfunction
  function automatic logic [132:0] mkv(logic [3:0] req, logic [31:0] ins, logic [31:0] pc,
                                       logic we, logic [31:0] addr, logic [31:0] wd);
    return {req, ins, pc, we, addr, wd};
  endfunction

  // requirement, instruction, expected PC, we, dmem_addr, dmem_wdata
  localparam logic [132:0] VECS [NV] = '{
    mkv(4'd4,  enc_i(6'h0D, 0, 1, 16'h1234), 32'd0,   1'b0, 32'h0000_1234, 32'h0),          // R4
    mkv(4'd4,  enc_i(6'h0D, 0, 2, 16'h8000), 32'd4,   1'b0, 32'h0000_8000, 32'h0),          // R4 no sign
    mkv(4'd3,  enc_r(1, 2, 3, 6'h20),        32'd8,   1'b0, 32'h0000_9234, 32'h8000),       // R3 add
    mkv(4'd3,  enc_r(1, 2, 4, 6'h22),        32'd12,  1'b0, 32'hFFFF_9234, 32'h8000),       // R3 sub wraps
    mkv(4'd3,  enc_r(4, 4, 5, 6'h20),        32'd16,  1'b0, 32'hFFFF_2468, 32'hFFFF_9234),  // R3 add wraps
    mkv(4'd9,  enc_i(6'h0D, 1, 0, 16'hFFFF), 32'd20,  1'b0, 32'h0000_FFFF, 32'h0),          // R9 write r0
    mkv(4'd9,  enc_r(0, 0, 6, 6'h20),        32'd24,  1'b0, 32'h0,         32'h0),          // R9 r0 still 0
    mkv(4'd6,  enc_i(6'h2B, 0, 3, 16'h0008), 32'd28,  1'b1, 32'h0000_0008, 32'h9234),       // R6
    mkv(4'd6,  enc_i(6'h2B, 2, 4, 16'hFFFC), 32'd32,  1'b1, 32'h0000_7FFC, 32'hFFFF_9234),  // R6 neg offset
    mkv(4'd5,  enc_i(6'h23, 0, 7, 16'h0008), 32'd36,  1'b0, 32'h0000_0008, 32'h0),          // R5
    mkv(4'd5,  enc_i(6'h23, 2, 8, 16'hFFFC), 32'd40,  1'b0, 32'h0000_7FFC, 32'h0),          // R5 neg offset
    mkv(4'd5,  enc_r(7, 3, 9, 6'h22),        32'd44,  1'b0, 32'h0,         32'h9234),       // R5 loaded value
    mkv(4'd5,  enc_r(8, 4, 10, 6'h22),       32'd48,  1'b0, 32'h0,         32'hFFFF_9234),  // R5 loaded value
    mkv(4'd7,  enc_i(6'h04, 1, 2, 16'h0005), 32'd52,  1'b0, 32'hFFFF_9234, 32'h8000),       // R7 not taken
    mkv(4'd7,  enc_i(6'h04, 7, 3, 16'h0002), 32'd56,  1'b0, 32'h0,         32'h9234),       // R7 forward
    mkv(4'd7,  enc_i(6'h04, 0, 0, 16'hFFFD), 32'd68,  1'b0, 32'h0,         32'h0),          // R7 backward
    mkv(4'd8,  enc_j(26'h20),                32'd60,  1'b0, 32'h0,         32'h0),          // R8
    mkv(4'd11, enc_i(6'h3F, 1, 2, 16'h0000), 32'd128, 1'b0, 32'h0000_9234, 32'h8000),       // R11 R10
    mkv(4'd10, enc_r(4, 1, 3, 6'h25),        32'd132, 1'b0, 32'hFFFF_A468, 32'h1234),       // R10 bad funct
    mkv(4'd10, enc_r(3, 2, 11, 6'h20),       32'd136, 1'b0, 32'h0001_1234, 32'h8000)        // R10 r2,r3 kept
  };

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  initial begin
    imem_data = 32'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "pc in reset", imem_addr, 32'h0);
    rst = 1'b0;
    for (int k = 0; k < NV; k++) begin
      string tag;
      imem_data = VECS[k][128:97];
      #1;
      tag = $sformatf("R%0d", VECS[k][132:129]);
      chk(tag, "pc", imem_addr, VECS[k][96:65]);
      chk(tag, "we", {31'd0, dmem_we}, {31'd0, VECS[k][64]});
      chk(tag, "addr", dmem_addr, VECS[k][63:32]);
      chk(tag, "wdata", dmem_wdata, VECS[k][31:0]);
      @(negedge clk);
    end
    // Directed: reset in mid-run returns PC to 0 and clears registers (R1)
    imem_data = 32'h0;
    rst = 1'b1;
    @(negedge clk);
    chk("R1", "pc after reset", imem_addr, 32'h0);
    rst = 1'b0;
    imem_data = enc_r(3, 11, 0, 6'h20);
    #1;
    chk("R1", "r3+r11 after reset", dmem_addr, 32'h0);
    chk("R1", "r11 after reset", dmem_wdata, 32'h0);
    @(negedge clk);
    chk("R2", "step after reset", imem_addr, 32'd4);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule